// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller

This block holds the tag and state side of a small data cache that sits on a processor's data port. The cache is two-way set associative, each line carries four 32-bit words (128 bits), and stores go straight through to backing memory. For every request the controller decides whether it hits. On a read miss it picks a victim way and holds the port stalled for a fixed refill time. It also keeps a running total of every cycle the port spent stalled.

A request is accepted in any cycle where `req_valid_i` is high and `stall_o` is low. `hit_o` reports the lookup result in that same cycle. A read miss installs the new tag in the least recently used way of its set when its stall window ends. A store that misses leaves the tag state exactly as it was. The data array, the timing of the real memory bus and coherence belong to other blocks.

The request address is a word address. Bits [1:0] select the word within the line. The next log2(SETS) bits select the set, and the remaining upper bits form the tag.

Top module: `wtc_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `stall_o` is low and `delay_cnt_o` is zero, so the first access to any address misses.
- R2: A read whose tag matches a valid way of its set raises `hit_o` in the accept cycle and causes no stall.
- R3: A read miss raises `stall_o` from the cycle after acceptance for exactly MISS_CYCLES cycles.
- R4: Once a read miss's stall window ends, a read of any word of that line hits.
- R5: A read miss refills the least recently used way of its set, so two different tags in one set can be resident together, and a third tag evicts only the less recent one.
- R6: Every hit, read or write, marks the way it hit as most recently used in its set.
- R7: A write miss changes neither valid bits, tags nor replacement state, so a following read of that address still misses.
- R8: A write hit raises `hit_o` and updates replacement state, but leaves valid bits and tags unchanged.
- R9: Every write, hit or miss, is passed through to memory and stalls the port for WRITE_CYCLES cycles starting the cycle after acceptance.
- R10: `delay_cnt_o` grows by exactly one in each cycle that `stall_o` is high and holds otherwise.
- R11: Requests presented while `stall_o` is high are ignored: `hit_o` stays low and no state changes.
- R12: The word offset bits [1:0] do not affect set selection or tag matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address: offset [1:0], then set index, then tag |
| hit_o | output | 1 | Accepted access hit a valid way (same cycle) |
| stall_o | output | 1 | Port busy with a refill or write-through; requests ignored |
| delay_cnt_o | output | CNT_W | Total stall cycles since reset |

## Verification
Directed sequences go to a single set. They fill both ways, re-touch the older way, and then bring in a third tag, which shows whether the victim is the true least recent way rather than a fixed or round-robin choice. A store miss followed by a load of the same address separates write no-allocate from allocate-on-write. A load at offset 0 followed by one at offset 3 shows whether the offset is kept out of the index and tag. Constrained random traffic then mixes loads and stores over a small tag pool so that hits, evictions and write misses interleave. Garbage requests are driven during every stall window, which exposes any lookup or state change that leaks through while the port is busy.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WAYS       = 2;
  localparam int LINE_WORDS = 4;
  localparam int OFF_W      = $clog2(LINE_WORDS);

  typedef logic [WAYS-1:0] way_vec_t;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
  import wtc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output way_vec_t         hit_way_o,
  output logic             victim_o,
  input  logic             touch_i,
  input  logic             touch_way_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_way_i
);
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0]                      lru_q;  // way to replace next

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_way_o[w] = valid_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  assign victim_o = lru_q[lk_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      lru_q   <= '0;
    end else begin
      if (touch_i) lru_q[lk_idx_i] <= ~touch_way_i;
      if (fill_i) begin
        valid_q[fill_idx_i][fill_way_i] <= 1'b1;
        tag_q[fill_idx_i][fill_way_i]   <= fill_tag_i;
        lru_q[fill_idx_i]               <= ~fill_way_i;
      end
    end
  end

  // a set never holds one tag twice
  assert_hit_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_way_o));

  // only refills may change valid or tag state
  assert_valid_only_on_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/wtc_stall_ctrl.sv
module wtc_stall_ctrl #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == LEN_W'(1));

  assert_no_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  assert_window_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/wtc_delay_ctr.sv
module wtc_delay_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/wtc_cache_ctrl.sv
module wtc_cache_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SETS        = 8,
  parameter int MISS_CYCLES = 10,
  parameter int WRITE_CYCLES = 2,
  parameter int CNT_W       = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int MAX_LEN = (MISS_CYCLES > WRITE_CYCLES) ? MISS_CYCLES : WRITE_CYCLES,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_o,
  output logic              stall_o,
  output logic [CNT_W-1:0]  delay_cnt_o
);
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  way_vec_t         hit_way;
  logic             victim, hit_any;
  logic             accept, rd_miss, wr_acc, start, last;
  logic [LEN_W-1:0] len;

  logic             fill_pend_q, fill_way_q;
  logic [IDX_W-1:0] fill_idx_q;
  logic [TAG_W-1:0] fill_tag_q;

  assign idx = req_addr_i[OFF_W +: IDX_W];
  assign tag = req_addr_i[ADDR_W-1 -: TAG_W];

  assign accept  = req_valid_i && !stall_o;
  assign hit_any = |hit_way;
  assign hit_o   = accept && hit_any;
  assign rd_miss = accept && !req_write_i && !hit_any;
  assign wr_acc  = accept && req_write_i;
  assign start   = rd_miss || (wr_acc && (WRITE_CYCLES != 0));
  assign len     = rd_miss ? LEN_W'(MISS_CYCLES) : LEN_W'(WRITE_CYCLES);

  wtc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_idx_i   (idx),
    .lk_tag_i   (tag),
    .hit_way_o  (hit_way),
    .victim_o   (victim),
    .touch_i    (hit_o),
    .touch_way_i(hit_way[1]),
    .fill_i     (fill_pend_q && last),
    .fill_idx_i (fill_idx_q),
    .fill_tag_i (fill_tag_q),
    .fill_way_i (fill_way_q)
  );

  wtc_stall_ctrl #(.LEN_W(LEN_W)) u_stall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .len_i  (len),
    .busy_o (stall_o),
    .last_o (last)
  );

  wtc_delay_ctr #(.CNT_W(CNT_W)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (stall_o),
    .count_o(delay_cnt_o)
  );

  // refill target captured at the miss, committed on the last stall cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_pend_q <= 1'b0;
      fill_way_q  <= 1'b0;
      fill_idx_q  <= '0;
      fill_tag_q  <= '0;
    end else if (rd_miss) begin
      fill_pend_q <= 1'b1;
      fill_way_q  <= victim;
      fill_idx_q  <= idx;
      fill_tag_q  <= tag;
    end else if (last) begin
      fill_pend_q <= 1'b0;
    end
  end

  assert_rd_miss_stalls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_miss |=> stall_o);

  assert_wr_stalls_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && (WRITE_CYCLES != 0)) |=> stall_o);

  assert_quiet_when_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !hit_o);

  assert_delay_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_cnt_o == $past(delay_cnt_o) + CNT_W'($past(stall_o)));
endmodule

// File: tb/wtc_cache_ctrl_bench.sv
module wtc_cache_ctrl_bench;
  localparam int ADDR_W = 16;
  localparam int SETS   = 8;
  localparam int MISS_N = 10;
  localparam int WR_N   = 2;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = ADDR_W - 2 - IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              hit;
  logic              stall;
  logic [31:0]       delay_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state
  bit              m_valid [SETS][2];
  bit [TAG_W-1:0]  m_tag   [SETS][2];
  bit              m_lru   [SETS];
  int unsigned     m_delay = 0;

  always #2.5 clk = ~clk;

  wtc_cache_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .MISS_CYCLES(MISS_N),
    .WRITE_CYCLES(WR_N), .CNT_W(32)
  ) u_wtc_cache_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .hit_o      (hit),
    .stall_o    (stall),
    .delay_cnt_o(delay_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
    return {TAG_W'(t), IDX_W'(s), 2'(o)};
  endfunction

  function automatic int find_way(input int s, input bit [TAG_W-1:0] t);
    for (int w = 0; w < 2; w++)
      if (m_valid[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input string lbl);
    int s, w, n;
    bit [TAG_W-1:0] t;
    string hl;
    s = int'(a[2 +: IDX_W]);
    t = a[ADDR_W-1 -: TAG_W];
    w = find_way(s, t);
    if (lbl != "") hl = lbl;
    else if (wr)   hl = (w >= 0) ? "R8" : "R7";
    else           hl = (w >= 0) ? "R2" : "R3";
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    #1;
    chk(hl, 32'(hit), 32'(w >= 0));
    @(posedge clk);
    @(negedge clk);
    n = wr ? WR_N : ((w >= 0) ? 0 : MISS_N);
    if (w >= 0) m_lru[s] = (w == 0);
    else if (!wr) begin
      int v;
      v = int'(m_lru[s]);
      m_valid[s][v] = 1'b1;
      m_tag[s][v]   = t;
      m_lru[s]      = (v == 0);
    end
    // noise during stall must be ignored (R11)
    req_valid = (n > 0); req_write = 1'($urandom); req_addr = ADDR_W'($urandom);
    for (int i = 0; i < n; i++) begin
      chk(wr ? "R9" : "R3", 32'(stall), 32'd1);
      chk("R11", 32'(hit), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(wr ? "R9" : "R3", 32'(stall), 32'd0);
    m_delay += n;
    chk("R10", delay_cnt, m_delay);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin m_valid[s][w] = 1'b0; m_tag[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", 32'(stall), 32'd0);
    chk("R1", delay_cnt, 32'd0);

    access(1'b0, mk(5, 1, 0), "R1");   // cold miss
    access(1'b0, mk(5, 1, 3), "R12");  // other word, same line hits
    access(1'b0, mk(5, 1, 1), "R4");
    access(1'b0, mk(9, 1, 0), "");     // second way
    access(1'b0, mk(9, 1, 2), "R5");   // both resident
    access(1'b0, mk(5, 1, 0), "R6");   // tag 9 now least recent
    access(1'b0, mk(3, 1, 0), "");     // evicts tag 9
    access(1'b0, mk(5, 1, 2), "R5");   // survivor
    access(1'b0, mk(9, 1, 0), "R6");   // evicted line misses
    access(1'b1, mk(7, 2, 0), "R7");   // write miss
    access(1'b0, mk(7, 2, 1), "R7");   // still a miss
    access(1'b1, mk(7, 2, 3), "R8");   // write hit
    access(1'b0, mk(7, 2, 0), "R8");   // tag intact

    for (int k = 0; k < 400; k++)
      access(1'($urandom_range(0, 2) == 0),
             mk($urandom_range(0, 3), $urandom_range(0, SETS - 1), $urandom_range(0, 3)), "");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule